// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block handles modem-style hardware flow control for one UART channel. On the transmit side it turns an active-low clear-to-send pin into a transmit-permit signal. It synchronizes the pin first. While transmission is running, it only decides to stop at a character boundary, so a character already being shifted out is never cut short. Once the transmitter is held, it resumes as soon as the synchronized pin shows the far end is ready again. If clear-to-send control is disabled, the pin is ignored.

On the receive side it drives an active-low request-to-send pin. The receive FIFO holds eight characters, and a ninth can wait in the receive shift register. So the request line is dropped (driven high) only when the FIFO is already full and the start bit of one more character is detected. That leaves nine valid characters in the receiver. A read from the FIFO releases the request line again. When request-to-send control is disabled, the block stops driving the pin and its held state is discarded. The serializer, deserializer and FIFOs sit outside this block and reach it through single-cycle strobes and a full flag.

Top module: `flow_handshake`

## Requirements
- R1: After reset `tx_permit` is 1 and the request-hold state is clear, so `rts_n` is 0 while `rts_en` is 1.
- R2: `cts_n` passes through SYNC_STAGES flops (default 2) before use. A level on the pin influences a boundary decision only if it was present at least SYNC_STAGES clock edges before the edge that samples `tx_boundary`.
- R3: With `cts_en` = 1 and transmission running, `tx_permit` falls in the cycle after an edge where `tx_boundary` = 1 and the synchronized `cts_n` is 1. It never falls at any other time.
- R4: With `cts_en` = 1 and transmission held, `tx_permit` returns to 1 one edge after the synchronized `cts_n` is seen as 0. No boundary strobe is needed for this.
- R5: With `cts_en` = 0, `tx_permit` is 1 from the next edge onward, whatever `cts_n` and `tx_boundary` do.
- R6: With `rts_en` = 1, `rts_n` goes to 1 the edge after `rx_full` = 1 and `rx_start` = 1 in the same cycle with `rx_pop` = 0. It stays at 1 while `rx_full` stays 1 and no read occurs.
- R7: With `rts_en` = 1 and `rts_n` at 1, an `rx_pop` pulse or `rx_full` going to 0 returns `rts_n` to 0 on the next edge.
- R8: If `rx_full`, `rx_start` and `rx_pop` are all 1 in the same cycle, the read wins. `rts_n` is 0 after that edge.
- R9: With `rts_en` = 0, `rts_oe` is 0, `rts_n` reads 1, and the request-hold state is cleared. Re-enabling therefore shows `rts_n` = 0 until a new full-plus-start event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| cts_en | input | 1 | 1 = transmitter obeys clear-to-send |
| rts_en | input | 1 | 1 = block drives the request-to-send pin |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_start | input | 1 | One-cycle strobe: receiver detected a start bit |
| tx_boundary | input | 1 | One-cycle strobe: transmitter at a character boundary |
| rx_pop | input | 1 | One-cycle strobe: a character was read from the receive FIFO |
| tx_permit | output | 1 | 1 = transmitter may start or continue characters |
| rts_n | output | 1 | Request-to-send pin value, active low |
| rts_oe | output | 1 | Output enable for the request-to-send pin |

## Verification
The interesting collision is on the receive side: a start bit arriving on a full FIFO in the very cycle a character is read out. The bench forces this directly, raising `rx_full`, `rx_start` and `rx_pop` together, and expects `rts_n` to stay low, with the read taking precedence over the hold. It also forces the same overlap on the transmit side: a boundary strobe arrives before a new clear-to-send level has crossed the synchronizer, and the bench expects the old level to decide. Long random runs with rarely toggling pins and enables then produce both collisions many more times. Each one is judged against a cycle model built from the requirements.

// File: rtl/flow_hs_pkg.sv
package flow_hs_pkg;
   typedef enum logic {
      TX_RUN  = 1'b0,
      TX_HELD = 1'b1
   } tx_state_e;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < flow_hs_pkg::MIN_SYNC_STAGES) begin : g_bad_depth
         $error("flow_sync: STAGES below minimum");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cts_gate.sv
module cts_gate
   import flow_hs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cts_n_sync,
   input  logic boundary,
   output logic permit
);
   tx_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!enable) begin
         state_d = TX_RUN;
      end else if (state_q == TX_HELD) begin
         state_d = cts_n_sync ? TX_HELD : TX_RUN;
      end else if (boundary && cts_n_sync) begin
         state_d = TX_HELD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TX_RUN;
      else        state_q <= state_d;
   end

   assign permit = (state_q == TX_RUN);
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic full,
   input  logic start,
   input  logic pop,
   output logic rts_n,
   output logic rts_oe
);
   logic hold_q, hold_d;
   logic overflow_risk;

   assign overflow_risk = full && start && !pop;

   always_comb begin
      hold_d = hold_q;
      if (!enable)            hold_d = 1'b0;
      else if (overflow_risk) hold_d = 1'b1;
      else if (pop || !full)  hold_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hold_d;
   end

   assign rts_n  = enable ? hold_q : 1'b1;
   assign rts_oe = enable;
endmodule

// File: rtl/flow_handshake.sv
module flow_handshake #(
   parameter int   SYNC_STAGES    = 2,
   parameter logic CTS_IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_n,
   input  logic cts_en,
   input  logic rts_en,
   input  logic rx_full,
   input  logic rx_start,
   input  logic tx_boundary,
   input  logic rx_pop,
   output logic tx_permit,
   output logic rts_n,
   output logic rts_oe
);
   logic cts_n_sync;

   flow_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTS_IDLE_LEVEL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_n),
      .q     (cts_n_sync)
   );

   cts_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cts_en),
      .cts_n_sync (cts_n_sync),
      .boundary   (tx_boundary),
      .permit     (tx_permit)
   );

   rts_ctrl u_rts (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (rts_en),
      .full   (rx_full),
      .start  (rx_start),
      .pop    (rx_pop),
      .rts_n  (rts_n),
      .rts_oe (rts_oe)
   );
endmodule

// File: rtl/flow_handshake_chk.sv
module flow_handshake_chk (
   input logic clk,
   input logic rst_n,
   input logic cts_en,
   input logic rts_en,
   input logic rx_full,
   input logic rx_start,
   input logic tx_boundary,
   input logic rx_pop,
   input logic tx_permit,
   input logic rts_n,
   input logic rts_oe
);
   // R3
   permit_drop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_permit && $past(tx_permit)) |-> $past(tx_boundary && cts_en));

   // R5
   cts_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cts_en |=> tx_permit);

   // R6
   rts_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_n && !$past(rts_n) && rts_en && $past(rts_en))
         |-> $past(rx_full && rx_start && !rx_pop));

   // R7
   rts_pop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_en && rx_pop) |=> (!rts_n || !rts_en));

   // R8
   rts_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_en && !rts_n && rx_full && rx_start && rx_pop) |=> (!rts_n || !rts_en));

   // R9
   rts_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rts_en |-> (rts_n && !rts_oe));
endmodule

bind flow_handshake flow_handshake_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cts_en      (cts_en),
   .rts_en      (rts_en),
   .rx_full     (rx_full),
   .rx_start    (rx_start),
   .tx_boundary (tx_boundary),
   .rx_pop      (rx_pop),
   .tx_permit   (tx_permit),
   .rts_n       (rts_n),
   .rts_oe      (rts_oe)
);

// File: tb/test_flow_handshake.sv
module test_flow_handshake;
   localparam time CLK_HALF = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cts_n = 1'b1, cts_en = 1'b0, rts_en = 1'b0;
   logic rx_full = 1'b0, rx_start = 1'b0, tx_boundary = 1'b0, rx_pop = 1'b0;
   logic tx_permit, rts_n, rts_oe;

   int checks = 0;
   int errors = 0;

   // cycle model built from the requirements
   logic m_s1, m_s2, m_halt, m_hold;

   always #(CLK_HALF) clk = ~clk;

   flow_handshake i_flow_handshake (
      .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .cts_en(cts_en), .rts_en(rts_en),
      .rx_full(rx_full), .rx_start(rx_start), .tx_boundary(tx_boundary),
      .rx_pop(rx_pop), .tx_permit(tx_permit), .rts_n(rts_n), .rts_oe(rts_oe)
   );

   function automatic logic next_halt(logic en, logic halt, logic syn, logic bnd);
      if (!en)      return 1'b0;
      else if (halt) return syn;
      else if (bnd)  return syn;
      else           return 1'b0;
   endfunction

   function automatic logic next_hold(logic en, logic hold, logic full,
                                      logic start, logic pop);
      if (!en)                        return 1'b0;
      else if (full && start && !pop) return 1'b1;
      else if (pop || !full)          return 1'b0;
      else                            return hold;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 1'b1; m_s2 <= 1'b1; m_halt <= 1'b0; m_hold <= 1'b0;
      end else begin
         m_s1   <= cts_n;
         m_s2   <= m_s1;
         m_halt <= next_halt(cts_en, m_halt, m_s2, tx_boundary);
         m_hold <= next_hold(rts_en, m_hold, rx_full, rx_start, rx_pop);
      end
   end

   task automatic check_bit(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      string tp, tr;
      tp = tag; tr = tag;
      if (tag == "") begin
         tp = !cts_en ? "R5" : (m_halt ? "R4" : "R3");
         tr = !rts_en ? "R9" : (m_hold ? "R6" : "R7");
      end
      check_bit(tp, "tx_permit", tx_permit, !m_halt);
      check_bit(tr, "rts_n", rts_n, rts_en ? m_hold : 1'b1);
      check_bit(tr, "rts_oe", rts_oe, rts_en);
   endtask

   task automatic cyc(logic pin, logic ce, logic re, logic full, logic st,
                      logic bnd, logic pop, string tag);
      cts_n = pin; cts_en = ce; rts_en = re; rx_full = full;
      rx_start = st; tx_boundary = bnd; rx_pop = pop;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(CLK_HALF * 2 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic pin, ce, re, full;
      void'($urandom(32'h0000_5eed));
      rts_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_bit("R1", "tx_permit", tx_permit, 1'b1);
      check_bit("R1", "rts_n", rts_n, 1'b0);

      // R2: boundary one edge after pin rises sees old level
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      check_bit("R2", "permit kept", tx_permit, 1'b1);
      // R3: level now crossed, next boundary halts
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
      check_bit("R3", "halted", tx_permit, 1'b0);
      // R4: release without boundary
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      check_bit("R4", "resumed", tx_permit, 1'b1);
      // R6: full plus start raises rts_n
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      check_bit("R6", "rts raised", rts_n, 1'b1);
      // R7: pop releases
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
      check_bit("R7", "rts released", rts_n, 1'b0);
      // R8: start and pop together on full FIFO
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
      check_bit("R8", "read wins", rts_n, 1'b0);
      // R9: disable then re-enable clears hold
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
      check_bit("R9", "hold cleared", rts_n, 1'b0);
      // R5: disabled CTS ignores a high pin at boundaries
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
      check_bit("R5", "pin ignored", tx_permit, 1'b1);

      // constrained random phase
      pin = 1'b0; ce = 1'b1; re = 1'b1; full = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(7) == 0)  pin  = ~pin;
         if ($urandom_range(63) == 0) ce   = ~ce;
         if ($urandom_range(63) == 0) re   = ~re;
         if ($urandom_range(5) == 0)  full = ~full;
         cyc(pin, ce, re, full,
             $urandom_range(2) == 0,
             $urandom_range(3) == 0,
             $urandom_range(4) == 0, "");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule